// File: doc/BRIEF.md
# Validity-Aware Cache Way Gating Controller

This block is the per-partition controller that turns a requested number of active ways per set into clock-gate controls for the individual lines of a set-associative cache. Software or a power manager supplies a target active-way count and pulses a start input. The controller then sweeps every set in ascending index order. For each set it first decides how many lines must be switched off, then chooses which ones. A line may only be switched off when its valid bit, read from the tag array, is clear. A set is never switched off in full, so address decoding stays as it was.

While a set is under reconfiguration the controller raises that set's busy bit, and the cache controller stalls requests to that set until the bit drops. When more invalid lines qualify than are needed, the choice is spread pseudo-randomly: a 16-bit LFSR supplies a rotating start way, and the ways are scanned in rising order from that point. If a set has too few invalid lines, only those that are available are gated, and a later sweep may finish the job. When the target rises above what a set currently provides, all of that set's gate bits are dropped without looking at validity, and the set is then refilled towards the new target.

Top module: `way_gate_ctrl`

## Requirements
- R1: A start pulse while idle begins a sweep. Each set takes two cycles, a count cycle followed by an apply cycle, with sets visited in index order 0 to NUM_SETS-1. During both cycles `set_busy_o` has exactly the bit of that set high and `rd_set_o` holds its index. `done_o` is high for one cycle directly after the last apply cycle, which is 2*NUM_SETS+1 cycles after the start cycle.
- R2: No set ever has all of its ways gated. Gate bit for set s, way w is `gate_o[s*NUM_WAYS+w]`, and 1 means gated.
- R3: An apply cycle never newly gates a way whose `valid_i` bit is 1.
- R4: After a set's apply cycle, its gated-way count is min(NUM_WAYS - target, gated ways kept + qualifying invalid ways), where the target has been clamped as in R10.
- R5: When a set has fewer invalid ways than the number needed, every one of its available invalid ways is gated and the set stays below the target.
- R6: When a set holds more gated ways than the new target allows, all of its gate bits are cleared in the apply cycle without any validity check, and the set is refilled from its invalid ways only.
- R7: Candidates are scanned from start way `lfsr[log2(NUM_WAYS)-1:0]` in rising way order, wrapping round, and the first qualifying invalid ways are taken. The LFSR resets to 16'hACE1 and steps once per apply cycle as `{s[14:0], s[15]^s[13]^s[12]^s[10]}`.
- R8: A start pulse during a sweep is ignored. The running sweep keeps its own target and ends with a single `done_o` pulse.
- R9: After reset all gate bits, `set_busy_o` and `done_o` are 0.
- R10: A target of 0 is treated as 1, and a target above NUM_WAYS is treated as NUM_WAYS.
- R11: Gate bits change only in a cycle in which some set is busy, and only for that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sweep; only taken when idle |
| target_ways_i | input | $clog2(NUM_WAYS+1) | Requested active ways per set |
| valid_i | input | NUM_WAYS | Valid bits of set `rd_set_o`, read from the tag array in the same cycle |
| rd_set_o | output | $clog2(NUM_SETS) | Set being processed; tag array read index |
| set_busy_o | output | NUM_SETS | One-hot stall request for the set being gated |
| gate_o | output | NUM_SETS*NUM_WAYS | Per-set, per-way clock-gate bits |
| done_o | output | 1 | One-cycle sweep-complete pulse |

## Verification
The bench builds the block with 8 sets of 4 ways. With these sizes a full sweep takes only 17 cycles, so many sweeps fit in a short run. The small way count lets targets of 0, 4 and 7 test the clamping at both ends, and it leaves sets that have fewer invalid ways than needed. A 2-bit start way means every rotation offset of the LFSR occurs within a few sets, so the wrap-around scan is exercised early.

// File: rtl/way_gate_pkg.sv
package way_gate_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COUNT = 2'd1,
    PH_APPLY = 2'd2,
    PH_DONE  = 2'd3
  } walk_ph_t;

  // Population count over up to 32 ways.
  function automatic int ones32(input logic [31:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  // One step of the rotating-start generator (taps 15, 13, 12, 10).
  function automatic logic [15:0] lfsr16_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/way_lfsr.sv
module way_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv_i,
  output logic [15:0] state_o
);
  import way_gate_pkg::*;

  logic [15:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= SEED;
    else if (adv_i) state_q <= lfsr16_step(state_q);
  end

  assign state_o = state_q;
endmodule

// File: rtl/way_picker.sv
module way_picker #(
  parameter int NUM_WAYS = 8,
  localparam int WW = $clog2(NUM_WAYS),
  localparam int CW = $clog2(NUM_WAYS + 1)
) (
  input  logic [NUM_WAYS-1:0] row_i,
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic [WW-1:0]       start_way_i,
  input  logic                clear_i,
  input  logic [CW-1:0]       desired_i,
  output logic [NUM_WAYS-1:0] row_o
);
  import way_gate_pkg::*;

  logic [NUM_WAYS-1:0] base;
  int cnt;
  int w;

  always_comb begin
    base  = clear_i ? '0 : row_i;
    row_o = base;
    cnt   = ones32(32'(base));
    w     = 0;
    for (int k = 0; k < NUM_WAYS; k++) begin
      w = (int'(start_way_i) + k) % NUM_WAYS;
      if (cnt < int'(desired_i) && !valid_i[w] && !base[w]) begin
        row_o[w] = 1'b1;
        cnt      = cnt + 1;
      end
    end
  end
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl #(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 8,
  localparam int SW = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int CW = $clog2(NUM_WAYS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [CW-1:0]         target_i,
  output way_gate_pkg::walk_ph_t phase_o,
  output logic [SW-1:0]         idx_o,
  output logic [CW-1:0]         desired_o
);
  import way_gate_pkg::*;

  walk_ph_t      phase_q;
  logic [SW-1:0] idx_q;
  logic [CW-1:0] desired_q;
  logic [CW-1:0] tgt_eff;

  always_comb begin
    if (target_i == '0)                  tgt_eff = CW'(1);
    else if (target_i > CW'(NUM_WAYS))   tgt_eff = CW'(NUM_WAYS);
    else                                 tgt_eff = target_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      idx_q     <= '0;
      desired_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q   <= PH_COUNT;
          idx_q     <= '0;
          desired_q <= CW'(NUM_WAYS) - tgt_eff;
        end
        PH_COUNT: phase_q <= PH_APPLY;
        PH_APPLY: begin
          if (idx_q == SW'(NUM_SETS - 1)) phase_q <= PH_DONE;
          else begin
            idx_q   <= idx_q + SW'(1);
            phase_q <= PH_COUNT;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o   = phase_q;
  assign idx_o     = idx_q;
  assign desired_o = desired_q;
endmodule

// File: rtl/way_gate_ctrl.sv
module way_gate_ctrl #(
  parameter int          NUM_SETS  = 64,
  parameter int          NUM_WAYS  = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          start_i,
  input  logic [$clog2(NUM_WAYS+1)-1:0]                 target_ways_i,
  input  logic [NUM_WAYS-1:0]                           valid_i,
  output logic [((NUM_SETS > 1) ? $clog2(NUM_SETS) : 1)-1:0] rd_set_o,
  output logic [NUM_SETS-1:0]                           set_busy_o,
  output logic [NUM_SETS*NUM_WAYS-1:0]                  gate_o,
  output logic                                          done_o
);
  import way_gate_pkg::*;

  localparam int SW = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
  localparam int CW = $clog2(NUM_WAYS + 1);
  localparam int WW = $clog2(NUM_WAYS);

  walk_ph_t                         phase;
  logic [SW-1:0]                    idx;
  logic [CW-1:0]                    desired;
  logic [15:0]                      lfsr;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0] gate_q;
  logic                             clear_q;

  // Named internal events for the checker.
  logic                apply_fire;
  logic                busy_phase;
  logic [NUM_WAYS-1:0] cur_row;
  logic [NUM_WAYS-1:0] pick_row;

  assign apply_fire = (phase == PH_APPLY);
  assign busy_phase = (phase == PH_COUNT) || (phase == PH_APPLY);
  assign cur_row    = gate_q[idx];

  walk_ctrl #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .target_i  (target_ways_i),
    .phase_o   (phase),
    .idx_o     (idx),
    .desired_o (desired)
  );

  way_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (apply_fire),
    .state_o (lfsr)
  );

  way_picker #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .row_i       (cur_row),
    .valid_i     (valid_i),
    .start_way_i (lfsr[WW-1:0]),
    .clear_i     (clear_q),
    .desired_i   (desired),
    .row_o       (pick_row)
  );

  // Count cycle: decide whether the set holds more gated ways than allowed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 clear_q <= 1'b0;
    else if (phase == PH_COUNT) clear_q <= ones32(32'(cur_row)) > int'(desired);
  end

  // Apply cycle: write back the chosen row.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gate_q      <= '0;
    else if (apply_fire) gate_q[idx] <= pick_row;
  end

  always_comb begin
    set_busy_o = '0;
    if (busy_phase) set_busy_o[idx] = 1'b1;
  end

  assign rd_set_o = idx;
  assign gate_o   = gate_q;
  assign done_o   = (phase == PH_DONE);
endmodule

// File: rtl/way_gate_checker.sv
module way_gate_checker #(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 8,
  localparam int SW = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int CW = $clog2(NUM_WAYS + 1)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_SETS*NUM_WAYS-1:0] gate_o,
  input logic [NUM_SETS-1:0]          set_busy_o,
  input logic [SW-1:0]                rd_set_o,
  input logic                         done_o,
  input logic [NUM_WAYS-1:0]          valid_i,
  input logic                         apply_fire,
  input logic [NUM_WAYS-1:0]          cur_row,
  input logic [NUM_WAYS-1:0]          pick_row,
  input logic [CW-1:0]                desired
);
  import way_gate_pkg::*;

  function automatic logic any_full(input logic [NUM_SETS*NUM_WAYS-1:0] g);
    logic hit;
    hit = 1'b0;
    for (int s = 0; s < NUM_SETS; s++)
      if (g[s*NUM_WAYS +: NUM_WAYS] == {NUM_WAYS{1'b1}}) hit = 1'b1;
    return hit;
  endfunction

  assert_busy_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_busy_o));

  assert_busy_on_read_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_busy_o != '0) |-> set_busy_o[rd_set_o]);

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_never_full_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_full(gate_o));

  assert_no_valid_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    apply_fire |-> ((pick_row & ~cur_row & valid_i) == '0));

  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    apply_fire |-> (ones32(32'(pick_row)) <= int'(desired)));

  assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_busy_o == '0) |=> $stable(gate_o));
endmodule

bind way_gate_ctrl way_gate_checker #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gate_o     (gate_o),
  .set_busy_o (set_busy_o),
  .rd_set_o   (rd_set_o),
  .done_o     (done_o),
  .valid_i    (valid_i),
  .apply_fire (apply_fire),
  .cur_row    (cur_row),
  .pick_row   (pick_row),
  .desired    (desired)
);

// File: tb/way_gate_ctrl_tb.sv
module way_gate_ctrl_tb;
  localparam int NS = 8;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    target = '0;
  logic [NW-1:0] valid_in;
  logic [2:0]    rd_set;
  logic [NS-1:0] busy;
  logic [NS*NW-1:0] gate;
  logic          done;

  logic [NW-1:0] vmem [NS];
  int checks = 0;
  int fails  = 0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;

  assign valid_in = vmem[rd_set];

  way_gate_ctrl #(.NUM_SETS(NS), .NUM_WAYS(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .target_ways_i(target),
    .valid_i(valid_in), .rd_set_o(rd_set), .set_busy_o(busy),
    .gate_o(gate), .done_o(done));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int cnt_bits(input logic [31:0] v);
    int n = 0;
    foreach (v[i]) if (v[i]) n++;
    return n;
  endfunction

  // ---------------- behavioural reference model ----------------
  int          m_st, m_idx, m_des;
  bit          m_clr;
  logic [15:0] m_lfsr;
  logic [NS*NW-1:0] m_gate;

  function automatic int clamp_t(input int t);
    if (t < 1) return 1;
    if (t > NW) return NW;
    return t;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_des = 0; m_clr = 0; m_lfsr = 16'hACE1; m_gate = '0;
    end else begin
      case (m_st)
        0: if (start) begin
             m_des = NW - clamp_t(int'(target)); m_idx = 0; m_st = 1;
           end
        1: begin
             m_clr = cnt_bits(32'(m_gate[m_idx*NW +: NW])) > m_des; m_st = 2;
           end
        2: begin
             logic [NW-1:0] row;
             int need, sw, w;
             row  = m_clr ? '0 : m_gate[m_idx*NW +: NW];
             need = m_des - cnt_bits(32'(row));
             sw   = int'(m_lfsr) % NW;
             for (int k = 0; k < NW; k++) begin
               w = (sw + k) % NW;
               if (need > 0 && !vmem[m_idx][w] && !row[w]) begin
                 row[w] = 1'b1; need--;
               end
             end
             m_gate[m_idx*NW +: NW] = row;
             m_lfsr = (m_lfsr << 1) | 16'(^(m_lfsr & 16'hB400));
             if (m_idx == NS - 1) m_st = 3;
             else begin m_idx++; m_st = 1; end
           end
        default: m_st = 0;
      endcase
    end
  end

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      logic [NS-1:0] eb;
      eb = (m_st == 1 || m_st == 2) ? NS'(1) << m_idx : '0;
      chk(busy == eb, "R1", "set_busy", busy, eb);
      if (eb != '0) chk(int'(rd_set) == m_idx, "R1", "rd_set", rd_set, m_idx);
      chk(done == (m_st == 3), "R1", "done", done, (m_st == 3));
      chk(gate == m_gate, "R4 R7 R11", "gate vs model", gate, m_gate);
    end
  end

  // Run one sweep; returns negedges from start to done.
  task automatic sweep(input int t, output int lat);
    @(negedge clk); start = 1'b1; target = 3'(t);
    lat = 0;
    @(negedge clk); start = 1'b0; lat = 1;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
  endtask

  task automatic check_counts(input int t, input string req);
    int cap, exp;
    cap = NW - clamp_t(t);
    for (int s = 0; s < NS; s++) begin
      exp = NW - cnt_bits(32'(vmem[s]));
      if (exp > cap) exp = cap;
      chk(cnt_bits(32'(gate[s*NW +: NW])) == exp, req, $sformatf("gated count set %0d", s),
          cnt_bits(32'(gate[s*NW +: NW])), exp);
      chk((gate[s*NW +: NW] & vmem[s]) == '0, "R3", $sformatf("valid gated set %0d", s),
          gate[s*NW +: NW] & vmem[s], 0);
      chk(gate[s*NW +: NW] != {NW{1'b1}}, "R2", $sformatf("full set %0d", s),
          gate[s*NW +: NW], 0);
    end
  endtask

  // New validity pattern; gated ways always stay invalid.
  task automatic load_valid(input int mul, input int add);
    @(negedge clk);
    for (int s = 0; s < NS; s++)
      vmem[s] = NW'(s * mul + add) & ~gate[s*NW +: NW];
  endtask

  initial begin
    int lat, dn;
    for (int s = 0; s < NS; s++) vmem[s] = '0;
    repeat (3) @(negedge clk);
    chk(gate == '0, "R9", "gate after reset", gate, 0);
    chk(busy == '0, "R9", "busy after reset", busy, 0);
    chk(done == 1'b0, "R9", "done after reset", done, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // All invalid, target 2: two ways gated per set; rotating start.
    sweep(2, lat);
    chk(lat == 2 * NS + 1, "R1", "sweep latency", lat, 2 * NS + 1);
    @(negedge clk);
    check_counts(2, "R4");
    chk(gate[3:0] == 4'b0110, "R7", "set0 ways from start 1", gate[3:0], 4'b0110);
    chk(gate[7:4] == 4'b1001, "R7", "set1 ways wrap from start 3", gate[7:4], 4'b1001);

    // Mixed validity, target 1: some sets lack enough invalid ways.
    load_valid(5, 3);
    vmem[6] = 4'hF & ~gate[6*NW +: NW];
    sweep(1, lat);
    @(negedge clk);
    check_counts(1, "R5");

    // Target rises to 3: over-gated sets clear and refill.
    load_valid(3, 1);
    sweep(3, lat);
    @(negedge clk);
    check_counts(3, "R6");

    // Target 0 behaves as 1.
    load_valid(7, 2);
    sweep(0, lat);
    @(negedge clk);
    check_counts(0, "R10");

    // Target above the way count behaves as NW: everything ungated.
    sweep(7, lat);
    @(negedge clk);
    chk(gate == '0, "R10", "target 7 clears all", gate, 0);

    // Start pulse during a sweep is ignored.
    load_valid(1, 0);
    @(negedge clk); start = 1'b1; target = 3'd2;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; target = 3'd4;
    @(negedge clk); start = 1'b0;
    dn = 0;
    for (int i = 0; i < 3 * NS; i++) begin
      if (done) dn++;
      @(negedge clk);
    end
    chk(dn == 1, "R8", "done pulses", dn, 1);
    check_counts(2, "R8");

    cmp_en = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule